// File: doc/BRIEF.md
# Low-Power PWM Timer with Register Interface

A single-channel pulse-width timer behind a small word-addressed register bus. A power-of-two prescaler divides the core clock by 1 to 128. The prescaled ticks drive a 16-bit up-counter that runs from zero to a reload limit and then wraps to zero. The output is driven active while the count is above a compare threshold, and a polarity bit can invert the whole waveform.

Software has to follow a fixed order. The divider and polarity are set while the timer is off. The timer is then switched on. The reload limit and the compare threshold are loaded next; each load raises a completion flag. Software clears those flags through a separate write-one-to-clear address. The last step is the continuous-run command. Any write made out of this order is ignored. New limit and threshold values move into the live registers only at a counter wrap, so a period already in progress always finishes at its old length.

Top module: `lp_pwm_timer`

## Requirements
- R1: After reset every readable register returns 0 and `pwm_o` is 0.
- R2: While running, the output period is (reload+1)·2^n core cycles. n is the divider field in bits [2:0] of the setup register at word address 1, so the divider runs from 1 to 128. The counter never exceeds the live reload value and wraps to 0 after it.
- R3: The active time in each period is (reload − compare)·2^n core cycles, and the output is active exactly while count > compare.
- R4: Setting setup bit 4 (polarity) inverts the output. The idle level is 0 when the bit is clear and 1 when it is set.
- R5: A write to the setup register while the enable bit is 1 is ignored, and reading it back shows the old value.
- R6: A write to the reload register (address 2) or the compare register (address 3) while the timer is disabled is dropped, and reading it back shows the old value.
- R7: One prescaled tick after an accepted reload write, status bit 0 (address 4) sets. After an accepted compare write, status bit 1 sets. Writing 1 to the matching bit of the clear register (address 5) clears a flag, and the clear register reads as 0.
- R8: Control register (address 0) bit 0 is enable and bit 1 is continuous start. Writing 0 stops the counter, resets it to 0 and puts the output at its idle level.
- R9: The start bit takes effect only when the timer is already enabled. A start request made in the same write that enables the timer is not kept.
- R10: When compare ≥ reload, or when both are 0, the output stays idle for the whole period.
- R11: Reload and compare values move into the live registers at a counter wrap. While the counter is stopped they move on the next prescaled tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1 |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pwm_o | output | 1 | PWM output |

## Verification
The waveform is measured on the output pin. The bench counts the active cycles and the full period between rising edges, then compares them with (reload−compare)·2^n and (reload+1)·2^n. Directed settings cover the smallest divider, the largest divider and inverted polarity. These separate an error in the divider from an error in the wrap point or in the compare. Random reload, compare and divider settings with a fixed seed then vary the duty across the whole range. Threshold settings at or above the limit, and both values at zero, check the forced-idle cases. Out-of-order writes are checked by reading the registers back and the flags through the status register.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 3'd0,
    A_SETUP   = 3'd1,
    A_RELOAD  = 3'd2,
    A_COMPARE = 3'd3,
    A_STATUS  = 3'd4,
    A_CLEAR   = 3'd5
  } lpt_addr_e;

  // control bits
  localparam int CTL_EN  = 0;
  localparam int CTL_GO  = 1;
  // setup bits: divider in [PSC_W-1:0], polarity here
  localparam int SET_POL = 4;
  // status / clear bits
  localparam int FLG_RLD = 0;
  localparam int FLG_CMP = 1;
endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3,
  parameter int DW    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              tick_i,
  output logic              en_o,
  output logic              run_o,
  output logic [PSC_W-1:0]  presc_o,
  output logic              pol_o,
  output logic [CNT_W-1:0]  arr_o,
  output logic [CNT_W-1:0]  cmp_o
);
  logic             en_q, en_n, run_q, run_n, pol_q, pol_n;
  logic [PSC_W-1:0] presc_q, presc_n;
  logic [CNT_W-1:0] arr_q, arr_n, cmp_q, cmp_n;
  logic             arr_pend_q, arr_pend_n, cmp_pend_q, cmp_pend_n;
  logic [1:0]       flag_q, flag_n, flag_set, flag_clr;
  logic             wr, wr_ctrl, wr_setup, acc_arr, acc_cmp, wr_clr;

  assign wr       = req_i & we_i;
  assign wr_ctrl  = wr & (addr_i == A_CTRL);
  assign wr_setup = wr & (addr_i == A_SETUP) & ~en_q;
  assign acc_arr  = wr & (addr_i == A_RELOAD) & en_q;
  assign acc_cmp  = wr & (addr_i == A_COMPARE) & en_q;
  assign wr_clr   = wr & (addr_i == A_CLEAR);

  always_comb begin
    en_n    = en_q;
    run_n   = run_q;
    presc_n = presc_q;
    pol_n   = pol_q;
    arr_n   = arr_q;
    cmp_n   = cmp_q;
    if (wr_ctrl) begin
      en_n  = wdata_i[CTL_EN];
      run_n = wdata_i[CTL_EN] & (run_q | (en_q & wdata_i[CTL_GO]));
    end
    if (wr_setup) begin
      presc_n = wdata_i[PSC_W-1:0];
      pol_n   = wdata_i[SET_POL];
    end
    if (acc_arr) arr_n = wdata_i[CNT_W-1:0];
    if (acc_cmp) cmp_n = wdata_i[CNT_W-1:0];
    arr_pend_n = en_q & (acc_arr | (arr_pend_q & ~tick_i));
    cmp_pend_n = en_q & (acc_cmp | (cmp_pend_q & ~tick_i));
    flag_set            = '0;
    flag_set[FLG_RLD]   = arr_pend_q & tick_i;
    flag_set[FLG_CMP]   = cmp_pend_q & tick_i;
    flag_clr            = wr_clr ? wdata_i[1:0] : 2'b00;
    flag_n              = (flag_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      run_q      <= 1'b0;
      presc_q    <= '0;
      pol_q      <= 1'b0;
      arr_q      <= '0;
      cmp_q      <= '0;
      arr_pend_q <= 1'b0;
      cmp_pend_q <= 1'b0;
      flag_q     <= '0;
    end else begin
      en_q       <= en_n;
      run_q      <= run_n;
      presc_q    <= presc_n;
      pol_q      <= pol_n;
      arr_q      <= arr_n;
      cmp_q      <= cmp_n;
      arr_pend_q <= arr_pend_n;
      cmp_pend_q <= cmp_pend_n;
      flag_q     <= flag_n;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[CTL_EN] = en_q;
        rdata_o[CTL_GO] = run_q;
      end
      A_SETUP: begin
        rdata_o[PSC_W-1:0] = presc_q;
        rdata_o[SET_POL]   = pol_q;
      end
      A_RELOAD:  rdata_o[CNT_W-1:0] = arr_q;
      A_COMPARE: rdata_o[CNT_W-1:0] = cmp_q;
      A_STATUS:  rdata_o[1:0] = flag_q;
      default:   rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign en_o    = en_q;
  assign run_o   = run_q;
  assign presc_o = presc_q;
  assign pol_o   = pol_q;
  assign arr_o   = arr_q;
  assign cmp_o   = cmp_q;
endmodule

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] presc_i,
  output logic             tick_o
);
  localparam int PCNT_W = (1 << PSC_W) - 1;

  logic [PCNT_W-1:0] pcnt_q, pcnt_n, limit;

  assign limit  = (PCNT_W'(1) << presc_i) - PCNT_W'(1);
  assign tick_o = en_i & (pcnt_q == limit);

  always_comb begin
    if (!en_i || tick_o) pcnt_n = '0;
    else                 pcnt_n = pcnt_q + PCNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else         pcnt_q <= pcnt_n;
  end
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] arr_sh_i,
  input  logic [CNT_W-1:0] cmp_sh_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] arr_act_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n, arr_q, arr_n, cmp_q, cmp_n;
  logic             wrap, load;

  assign wrap = (cnt_q == arr_q);
  assign load = tick_i & (~run_i | wrap);

  always_comb begin
    arr_n = load ? arr_sh_i : arr_q;
    cmp_n = load ? cmp_sh_i : cmp_q;
    if (!run_i)      cnt_n = '0;
    else if (tick_i) cnt_n = wrap ? '0 : cnt_q + CNT_W'(1);
    else             cnt_n = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      arr_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      arr_q <= arr_n;
      cmp_q <= cmp_n;
    end
  end

  assign pwm_o     = pol_i ^ (run_i & (cnt_q > cmp_q));
  assign cnt_o     = cnt_q;
  assign arr_act_o = arr_q;
  assign cmp_act_o = cmp_q;
endmodule

// File: rtl/lp_pwm_timer.sv
module lp_pwm_timer
  import lpt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3,
  parameter int DW    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              pwm_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             ctl_en, ctl_run, cfg_pol, tick;
  logic [PSC_W-1:0] cfg_presc;
  logic [CNT_W-1:0] arr_sh, cmp_sh, arr_act, cmp_act, cnt_val;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  lpt_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .tick_i  (tick),
    .en_o    (ctl_en),
    .run_o   (ctl_run),
    .presc_o (cfg_presc),
    .pol_o   (cfg_pol),
    .arr_o   (arr_sh),
    .cmp_o   (cmp_sh)
  );

  lpt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .en_i    (ctl_en),
    .presc_i (cfg_presc),
    .tick_o  (tick)
  );

  lpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .run_i     (ctl_run),
    .tick_i    (tick),
    .pol_i     (cfg_pol),
    .arr_sh_i  (arr_sh),
    .cmp_sh_i  (cmp_sh),
    .cnt_o     (cnt_val),
    .arr_act_o (arr_act),
    .cmp_act_o (cmp_act),
    .pwm_o     (pwm_o)
  );
endmodule

// File: rtl/lp_pwm_timer_chk.sv
module lp_pwm_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             en,
  input logic             run,
  input logic             tick,
  input logic             pol,
  input logic [PSC_W-1:0] presc,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] arr,
  input logic [CNT_W-1:0] cmp,
  input logic             pwm
);
  p_cnt_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    run |-> cnt <= arr);

  p_wrap_to_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run && tick && cnt == arr && en) |=> (!run || cnt == '0));

  p_setup_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(presc) && $stable(pol)));

  p_idle_when_stopped_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !run |-> pwm == pol);

  p_run_needs_enable_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en |-> !run);

  p_forced_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cmp >= arr) |-> pwm == pol);
endmodule

bind lp_pwm_timer lp_pwm_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk_i (clk_i),
  .rst_n (rst_n),
  .en    (ctl_en),
  .run   (ctl_run),
  .tick  (tick),
  .pol   (cfg_pol),
  .presc (cfg_presc),
  .cnt   (cnt_val),
  .arr   (arr_act),
  .cmp   (cmp_act),
  .pwm   (pwm_o)
);

// File: tb/lp_pwm_timer_tb.sv
`timescale 1ns/1ps
module lp_pwm_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        pwm;
  int          n_tests = 0, n_fail = 0;
  logic        cur_pol = 1'b0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  lp_pwm_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 3'(a); wdata = 32'(d);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = 3'(a);
    #1 d = int'(rdata);
  endtask

  function automatic int exp_period(input int a, input int p);
    return (a + 1) << p;
  endfunction

  function automatic int exp_high(input int a, input int c, input int p);
    return (c >= a) ? 0 : ((a - c) << p);
  endfunction

  task automatic setup(input int p, input bit pol, input int a, input int c);
    wr(0, 0);
    wr(1, (int'(pol) << 4) | p);
    wr(0, 1);
    wr(2, a);
    wr(3, c);
    wr(0, 3);
    cur_pol = pol;
    repeat (exp_period(a, p) * 3 + 300) @(negedge clk);
  endtask

  // active cycles and period measured between rising active edges
  task automatic measure(output int hi, output int per);
    int lim;
    hi = -1; per = -1;
    lim = 0;
    while ((pwm ^ cur_pol) && lim < 5000) begin @(negedge clk); lim++; end
    while (!(pwm ^ cur_pol) && lim < 5000) begin @(negedge clk); lim++; end
    if (lim >= 5000) return;
    hi = 0;
    while ((pwm ^ cur_pol) && hi < 5000) begin @(negedge clk); hi++; end
    per = hi;
    while (!(pwm ^ cur_pol) && per < 10000) begin @(negedge clk); per++; end
  endtask

  task automatic count_active(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm ^ cur_pol) n++;
    end
  endtask

  task automatic wave(input int p, input bit pol, input int a, input int c, input string tag);
    int hi, per;
    setup(p, pol, a, c);
    measure(hi, per);
    chk(per == exp_period(a, p), {tag, " R2 period"}, per, exp_period(a, p));
    chk(hi == exp_high(a, c, p), {tag, " R3 active"}, hi, exp_high(a, c, p));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v, n;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      chk(v == 0, "R1 reset readback", v, 0);
    end
    chk(pwm == 1'b0, "R1 reset output", int'(pwm), 0);

    // R9 start ignored when enabling in the same write
    wr(0, 3);
    rd(0, v);
    chk(v == 1, "R9 start with enable", v, 1);
    count_active(20, n);
    chk(n == 0, "R9 no output before start", n, 0);

    // R2/R3 smallest divider
    wave(0, 1'b0, 9, 3, "directed p0");

    // R7 completion flags
    rd(4, v);
    chk(v == 3, "R7 both flags set", v, 3);
    wr(5, 1);
    rd(4, v);
    chk(v == 2, "R7 clear reload flag", v, 2);
    rd(5, v);
    chk(v == 0, "R7 clear reg reads 0", v, 0);
    wr(5, 2);
    rd(4, v);
    chk(v == 0, "R7 clear compare flag", v, 0);

    // R5 setup write while enabled
    wr(1, 32'h13);
    rd(1, v);
    chk(v == 0, "R5 setup frozen", v, 0);

    // R11 update held to wrap: old period completes
    begin
      int hi, per;
      wave(0, 1'b0, 20, 10, "pre-update");
      measure(hi, per);
      wr(2, 5);
      wr(3, 2);
      measure(hi, per);
      chk(per == 21 || per == 6, "R11 period whole", per, 21);
      measure(hi, per);
      chk(per == 6, "R11 new period after wrap", per, 6);
      chk(hi == 3, "R11 new active after wrap", hi, 3);
    end

    // R2 largest divider
    wave(7, 1'b0, 3, 1, "directed p7");

    // R4 inverted polarity
    wave(1, 1'b1, 9, 6, "polarity");
    wr(0, 0);
    repeat (3) @(negedge clk);
    chk(pwm == 1'b1, "R4 idle level inverted", int'(pwm), 1);
    // R8 disable
    rd(0, v);
    chk(v == 0, "R8 control cleared", v, 0);
    count_active(40, n);
    chk(n == 0, "R8 output idle when off", n, 0);
    // R6 reload/compare dropped while disabled
    wr(2, 55);
    wr(3, 44);
    rd(2, v);
    chk(v == 9, "R6 reload dropped", v, 9);
    rd(3, v);
    chk(v == 6, "R6 compare dropped", v, 6);

    // R10 forced idle
    setup(0, 1'b0, 8, 8);
    count_active(40, n);
    chk(n == 0, "R10 compare equals reload", n, 0);
    setup(0, 1'b0, 8, 12);
    count_active(40, n);
    chk(n == 0, "R10 compare above reload", n, 0);
    setup(0, 1'b0, 0, 0);
    count_active(40, n);
    chk(n == 0, "R10 both zero", n, 0);

    // random settings, R2 R3
    for (int i = 0; i < 8; i++) begin
      int p, a, c;
      p = int'($urandom % 4);
      a = 4 + int'($urandom % 40);
      c = int'($urandom % a);
      wave(p, 1'($urandom % 2), a, c, "random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule